// File: doc/BRIEF.md
# Pulse-Width Field Write Modulator

This block produces the reader-field enable that programs a low-frequency read/write transponder. A one-cycle start strobe captures a 64-bit identifier and a 16-bit check value supplied by the host. The block then runs a fixed write session on one output, `field_en`, with no further input.

The session starts with a long field-on interval that charges the tag. The framed bit stream follows. Each bit occupies a fixed slot. The slot opens with a field-off gap, and the width of that gap encodes the bit value. The slot then closes with field on for the rest of its length. After the last slot the field stays on for a programming hold. A single-cycle `done` pulse then ends the session.

All durations are whole microsecond ticks. A prescaler derives the tick from the clock frequency parameter and restarts on each accepted start, so every interval is an exact number of clock cycles. The host computes the check value; this block only transmits it.

Top module: `lfw_pwm_writer`

## Requirements
- R1: After a synchronous reset, and while no session runs, `field_en`, `busy` and `done` are all low.
- R2: A start accepted while idle raises `field_en` and `busy` in the next cycle. The field then stays on for CHARGE_US ticks before the first gap.
- R3: A bit of value 1 is a field-off gap of ONE_GAP_US ticks followed by field on for SLOT_US minus ONE_GAP_US ticks.
- R4: A bit of value 0 is a field-off gap of ZERO_GAP_US ticks followed by field on for SLOT_US minus ZERO_GAP_US ticks.
- R5: Within every byte, bit 0 is sent first and bit 7 last.
- R6: The bytes go out in this order: 0xBB, 0xEB, identifier bytes from bits 7:0 up to bits 63:56, check value bits 7:0, check value bits 15:8, 0x00, 0x03. That makes 112 slots in total.
- R7: After the last slot's field-on part, the field stays on for another PROG_US ticks.
- R8: When the programming hold ends, `field_en` drops and `done` is high for exactly one cycle. The block is idle in the cycle after that.
- R9: A start that arrives while `busy` is high, including the `done` cycle, is ignored. The identifier and check value are sampled only at the accepted start.
- R10: One tick lasts CLK_HZ/TICK_HZ clock cycles, counted from the accepted start. Every field edge inside a session therefore falls on a tick boundary.
- R11: A synchronous reset in the middle of a session drops `field_en` and `busy` in the next cycle.
- R12: `busy` stays high from the cycle after acceptance through the `done` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a write session (taken only when idle) |
| tag_id | input | ID_W (64) | Identifier to transmit, sampled on acceptance |
| tag_crc | input | CRC_W (16) | Check value to transmit, sampled on acceptance |
| field_en | output | 1 | Reader field enable, high = carrier on |
| busy | output | 1 | Session in progress |
| done | output | 1 | One-cycle pulse at session end |

## Verification
The bound checker watches the handshake on every cycle:
- Idle implies field off and no `done`.
- An accepted start raises `busy` and the field.
- `done` is a single cycle, follows field-on and returns the block to idle.
- A reset always empties the session.
- Every in-session field edge sits on a tick.

Only the bench scenarios can show the correctness of the whole waveform. That covers the exact charge, gap, slot and hold lengths, the byte order, the LSB-first bit order, and the fact that a second start or changing inputs mid-session leave the transmitted frame unchanged. The bench shows this by comparing every cycle of each session against a model computed from the requirements.

// File: rtl/pwm_wr_pkg.sv
package pwm_wr_pkg;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_CHARGE,
      PH_GAP,
      PH_MARK,
      PH_PROG,
      PH_DONE
   } wr_phase_e;

   // Fixed framing bytes; their order on the air is behaviour
   localparam logic [7:0] HDR_KEY  = 8'hBB;
   localparam logic [7:0] HDR_PASS = 8'hEB;
   localparam logic [7:0] TRL_LO   = 8'h00;
   localparam logic [7:0] TRL_HI   = 8'h03;

   localparam int unsigned FRAMING_BITS = 32;

   function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                        input int unsigned c);
      int unsigned m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/pwm_wr_tick.sv
module pwm_wr_tick #(
   parameter int unsigned CLK_HZ  = 24_000_000,
   parameter int unsigned TICK_HZ = 1_000_000
) (
   input  logic clk,
   input  logic rst,
   input  logic sync,
   output logic tick
);
   localparam int unsigned DIV = CLK_HZ / TICK_HZ;
   localparam int unsigned CW  = (DIV > 1) ? $clog2(DIV) : 1;

   generate
      if (DIV == 1) begin : g_pass
         assign tick = 1'b1;
      end else begin : g_div
         logic [CW-1:0] cnt;
         always_ff @(posedge clk) begin
            if (rst || sync)                 cnt <= '0;
            else if (cnt == CW'(DIV - 1))    cnt <= '0;
            else                             cnt <= cnt + 1'b1;
         end
         assign tick = (cnt == CW'(DIV - 1));
      end
   endgenerate

endmodule

// File: rtl/pwm_wr_timer.sv
module pwm_wr_timer #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         tick,
   output logic         expire
);
   logic [W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst)                       cnt <= '0;
      else if (load)                 cnt <= load_val;
      else if (tick && cnt != '0)    cnt <= cnt - 1'b1;
   end

   // Last tick of the loaded interval
   assign expire = tick && (cnt == W'(1));

endmodule

// File: rtl/pwm_wr_frame.sv
module pwm_wr_frame
   import pwm_wr_pkg::*;
#(
   parameter int unsigned ID_W  = 64,
   parameter int unsigned CRC_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [ID_W-1:0]  id,
   input  logic [CRC_W-1:0] crc,
   input  logic             shift,
   output logic             cur_bit
);
   localparam int unsigned FB = FRAMING_BITS + ID_W + CRC_W;

   logic [FB-1:0] packed_w;
   logic [FB-1:0] sreg;

   // Bit 0 leaves first: header, id low byte upward, crc low byte, trailer
   assign packed_w = {TRL_HI, TRL_LO, crc, id, HDR_PASS, HDR_KEY};

   always_ff @(posedge clk) begin
      if (rst)        sreg <= '0;
      else if (load)  sreg <= packed_w;
      else if (shift) sreg <= {1'b0, sreg[FB-1:1]};
   end

   assign cur_bit = sreg[0];

endmodule

// File: rtl/pwm_wr_seq.sv
module pwm_wr_seq
   import pwm_wr_pkg::*;
#(
   parameter int unsigned CHARGE_US   = 50_000,
   parameter int unsigned SLOT_US     = 2000,
   parameter int unsigned ONE_GAP_US  = 1000,
   parameter int unsigned ZERO_GAP_US = 300,
   parameter int unsigned PROG_US     = 50_000,
   parameter int unsigned FRAME_BITS  = 112,
   parameter int unsigned TW          = 16
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          start,
   input  logic          expire,
   input  logic          cur_bit,
   output logic          accept,
   output logic          tmr_load,
   output logic [TW-1:0] tmr_val,
   output logic          bit_shift,
   output logic          field_en,
   output logic          busy,
   output logic          done
);
   localparam int unsigned BW = $clog2(FRAME_BITS);
   localparam logic [BW-1:0] LAST_BIT = BW'(FRAME_BITS - 1);

   localparam logic [TW-1:0] T_CHARGE = TW'(CHARGE_US);
   localparam logic [TW-1:0] T_PROG   = TW'(PROG_US);
   localparam logic [TW-1:0] T_GAP1   = TW'(ONE_GAP_US);
   localparam logic [TW-1:0] T_GAP0   = TW'(ZERO_GAP_US);
   localparam logic [TW-1:0] T_MARK1  = TW'(SLOT_US - ONE_GAP_US);
   localparam logic [TW-1:0] T_MARK0  = TW'(SLOT_US - ZERO_GAP_US);

   wr_phase_e     ph, ph_n;
   logic [BW-1:0] bit_idx, bit_idx_n;

   always_comb begin
      ph_n      = ph;
      bit_idx_n = bit_idx;
      accept    = 1'b0;
      tmr_load  = 1'b0;
      tmr_val   = '0;
      bit_shift = 1'b0;
      unique case (ph)
         PH_IDLE: if (start) begin
            accept    = 1'b1;
            tmr_load  = 1'b1;
            tmr_val   = T_CHARGE;
            bit_idx_n = '0;
            ph_n      = PH_CHARGE;
         end
         PH_CHARGE: if (expire) begin
            tmr_load = 1'b1;
            tmr_val  = cur_bit ? T_GAP1 : T_GAP0;
            ph_n     = PH_GAP;
         end
         PH_GAP: if (expire) begin
            tmr_load  = 1'b1;
            tmr_val   = cur_bit ? T_MARK1 : T_MARK0;
            bit_shift = 1'b1;
            ph_n      = PH_MARK;
         end
         PH_MARK: if (expire) begin
            tmr_load = 1'b1;
            if (bit_idx == LAST_BIT) begin
               tmr_val = T_PROG;
               ph_n    = PH_PROG;
            end else begin
               tmr_val   = cur_bit ? T_GAP1 : T_GAP0;
               bit_idx_n = bit_idx + 1'b1;
               ph_n      = PH_GAP;
            end
         end
         PH_PROG: if (expire) ph_n = PH_DONE;
         PH_DONE: ph_n = PH_IDLE;
         default: ph_n = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         ph      <= PH_IDLE;
         bit_idx <= '0;
      end else begin
         ph      <= ph_n;
         bit_idx <= bit_idx_n;
      end
   end

   assign field_en = (ph == PH_CHARGE) || (ph == PH_MARK) || (ph == PH_PROG);
   assign busy     = (ph != PH_IDLE);
   assign done     = (ph == PH_DONE);

endmodule

// File: rtl/lfw_pwm_writer.sv
module lfw_pwm_writer
   import pwm_wr_pkg::*;
#(
   parameter int unsigned CLK_HZ      = 24_000_000,
   parameter int unsigned TICK_HZ     = 1_000_000,
   parameter int unsigned CHARGE_US   = 50_000,
   parameter int unsigned SLOT_US     = 2000,
   parameter int unsigned ONE_GAP_US  = 1000,
   parameter int unsigned ZERO_GAP_US = 300,
   parameter int unsigned PROG_US     = 50_000,
   parameter int unsigned ID_W        = 64,
   parameter int unsigned CRC_W       = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start,
   input  logic [ID_W-1:0]  tag_id,
   input  logic [CRC_W-1:0] tag_crc,
   output logic             field_en,
   output logic             busy,
   output logic             done
);
   localparam int unsigned FRAME_BITS = FRAMING_BITS + ID_W + CRC_W;
   localparam int unsigned LONGEST    = max3(CHARGE_US, PROG_US, SLOT_US);
   localparam int unsigned TW         = $clog2(LONGEST + 1);

   generate
      if (TICK_HZ == 0 || CLK_HZ < TICK_HZ || (CLK_HZ % TICK_HZ) != 0) begin : g_bad_clk
         $error("CLK_HZ must be a nonzero whole multiple of TICK_HZ");
      end
      if (ZERO_GAP_US == 0 || ZERO_GAP_US >= ONE_GAP_US || ONE_GAP_US >= SLOT_US) begin : g_bad_slot
         $error("gap widths must satisfy 0 < ZERO_GAP_US < ONE_GAP_US < SLOT_US");
      end
      if (CHARGE_US == 0 || PROG_US == 0) begin : g_bad_hold
         $error("charge and programming holds must be nonzero");
      end
      if (ID_W == 0 || (ID_W % 8) != 0 || CRC_W == 0 || (CRC_W % 8) != 0) begin : g_bad_width
         $error("identifier and check widths must be whole bytes");
      end
   endgenerate

   logic          tick_w, expire_w, accept_w, load_w, shift_w, cur_bit_w;
   logic [TW-1:0] load_val_w;

   pwm_wr_tick #(.CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ)) u_tick (
      .clk (clk), .rst (rst), .sync (accept_w), .tick (tick_w)
   );

   pwm_wr_timer #(.W(TW)) u_timer (
      .clk (clk), .rst (rst), .load (load_w), .load_val (load_val_w),
      .tick (tick_w), .expire (expire_w)
   );

   pwm_wr_frame #(.ID_W(ID_W), .CRC_W(CRC_W)) u_frame (
      .clk (clk), .rst (rst), .load (accept_w), .id (tag_id), .crc (tag_crc),
      .shift (shift_w), .cur_bit (cur_bit_w)
   );

   pwm_wr_seq #(
      .CHARGE_US (CHARGE_US), .SLOT_US (SLOT_US), .ONE_GAP_US (ONE_GAP_US),
      .ZERO_GAP_US (ZERO_GAP_US), .PROG_US (PROG_US),
      .FRAME_BITS (FRAME_BITS), .TW (TW)
   ) u_seq (
      .clk (clk), .rst (rst), .start (start), .expire (expire_w),
      .cur_bit (cur_bit_w), .accept (accept_w), .tmr_load (load_w),
      .tmr_val (load_val_w), .bit_shift (shift_w),
      .field_en (field_en), .busy (busy), .done (done)
   );

endmodule

// File: rtl/pwm_wr_checker.sv
module pwm_wr_checker (
   input logic clk,
   input logic rst,
   input logic start,
   input logic busy,
   input logic field_en,
   input logic done,
   input logic tick
);
   // R1: idle means no field and no completion pulse
   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
      !busy |-> (!field_en && !done));

   // R2: accepted start turns the field on at once
   a_r2_start_field_on: assert property (@(posedge clk) disable iff (rst)
      (start && !busy) |=> field_en);

   // R12: accepted start raises busy
   a_r12_start_busy: assert property (@(posedge clk) disable iff (rst)
      (start && !busy) |=> busy);

   // R8: completion pulse lasts one cycle
   a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);

   // R8: block is idle right after the pulse
   a_r8_done_to_idle: assert property (@(posedge clk) disable iff (rst)
      done |=> !busy);

   // R7: the pulse follows the field-on programming hold
   a_r7_hold_before_done: assert property (@(posedge clk) disable iff (rst)
      done |-> ($past(field_en) && !field_en));

   // R10: in-session field edges sit on tick boundaries
   a_r10_edge_on_tick: assert property (@(posedge clk) disable iff (rst)
      (!$stable(field_en) && $past(busy) && !$past(rst)) |-> $past(tick));

   // R11: reset empties any session
   a_r11_reset_clears: assert property (@(posedge clk)
      rst |=> (!busy && !field_en && !done));

endmodule

bind lfw_pwm_writer pwm_wr_checker u_chk (
   .clk      (clk),
   .rst      (rst),
   .start    (start),
   .busy     (busy),
   .field_en (field_en),
   .done     (done),
   .tick     (tick_w)
);

// File: tb/lfw_pwm_writer_test.sv
module lfw_pwm_writer_test;

   localparam int D  = 2;    // clock cycles per tick
   localparam int C  = 20;   // charge ticks
   localparam int S  = 20;   // slot ticks
   localparam int G1 = 10;   // gap for a one
   localparam int G0 = 3;    // gap for a zero
   localparam int P  = 20;   // programming hold ticks
   localparam int NB = 112;  // slots per frame
   localparam int TEND = (C + NB * S + P) * D;

   logic        clk = 1'b0;
   logic        rst, start;
   logic [63:0] tag_id;
   logic [15:0] tag_crc;
   logic        field_en, busy, done;

   int n_vec = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   lfw_pwm_writer #(
      .CLK_HZ (2_000_000), .TICK_HZ (1_000_000), .CHARGE_US (C), .SLOT_US (S),
      .ONE_GAP_US (G1), .ZERO_GAP_US (G0), .PROG_US (P), .ID_W (64), .CRC_W (16)
   ) uut (
      .clk (clk), .rst (rst), .start (start), .tag_id (tag_id), .tag_crc (tag_crc),
      .field_en (field_en), .busy (busy), .done (done)
   );

   // R5, R6: transmitted order, bit k of the result goes out k-th
   function automatic logic [111:0] frame_of(input logic [63:0] id, input logic [15:0] crc);
      return {8'h03, 8'h00, crc[15:8], crc[7:0], id, 8'hEB, 8'hBB};
   endfunction

   // Expected {busy, field_en, done}, t = edges since the accepting edge
   function automatic logic [2:0] exp_out(input int t, input logic [111:0] fv);
      int t2, t3, b, r, g;
      if (t < C * D) return 3'b110;
      t2 = t - C * D;
      if (t2 < NB * S * D) begin
         b = t2 / (S * D);
         r = t2 % (S * D);
         g = fv[b] ? G1 : G0;
         return (r < g * D) ? 3'b100 : 3'b110;
      end
      t3 = t2 - NB * S * D;
      if (t3 < P * D)  return 3'b110;
      if (t3 == P * D) return 3'b101;
      return 3'b000;
   endfunction

   function automatic string region(input int t, input logic [111:0] fv);
      int t2;
      if (t < C * D) return "R2";
      t2 = t - C * D;
      if (t2 < NB * S * D) return fv[t2 / (S * D)] ? "R3" : "R4";
      if (t2 - NB * S * D < P * D) return "R7";
      if (t2 - NB * S * D == P * D) return "R8";
      return "R12";
   endfunction

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
   endtask

   // One full session; a second start (R9) is driven in the cycle after sample intr_t
   task automatic run_frame(input logic [63:0] id, input logic [15:0] crc,
                            input int intr_t, input logic [63:0] intr_id);
      logic [111:0] fv;
      logic [2:0]   got, e;
      bit           bad;
      int           first_fall;
      fv = frame_of(id, crc);
      bad = 0;
      first_fall = -1;
      @(negedge clk);
      tag_id  = id;
      tag_crc = crc;
      start   = 1'b1;
      for (int t = 0; t <= TEND + 1; t++) begin
         @(negedge clk);
         start   = 1'b0;
         tag_id  = ~id;          // R9: later input changes must not matter
         tag_crc = ~crc;
         got = {busy, field_en, done};
         e   = exp_out(t, fv);
         if (first_fall < 0 && !field_en) first_fall = t;
         if (got !== e && !bad) begin
            bad = 1;
            $display("FAIL %s t=%0d busy/field/done actual %b expected %b", region(t, fv), t, got, e);
         end
         if (t == intr_t) begin
            start  = 1'b1;
            tag_id = intr_id;
         end
      end
      start = 1'b0;
      // R3 R4 R5 R6 R7 R8 R9 R12: whole-session waveform
      n_vec++;
      if (bad) n_bad++;
      // R10: charge length in clock cycles
      n_vec++;
      if (first_fall != C * D) begin
         n_bad++;
         $display("FAIL R10 charge cycles actual %0d expected %0d", first_fall, C * D);
      end
   endtask

   task automatic check_idle(input string tag, input int cycles);
      bit bad;
      bad = 0;
      for (int i = 0; i < cycles; i++) begin
         @(negedge clk);
         if ({busy, field_en, done} !== 3'b000 && !bad) begin
            bad = 1;
            $display("FAIL %s idle outputs actual %b expected 000", tag, {busy, field_en, done});
         end
      end
      n_vec++;
      if (bad) n_bad++;
   endtask

   initial begin
      repeat (150_000) @(posedge clk);
      $display("FAIL watchdog expired");
      n_bad++;
      n_vec++;
      summary();
      $finish;
   end

   initial begin
      void'($urandom(32'h1CE5_0B5E));
      rst = 1'b1; start = 1'b0; tag_id = '0; tag_crc = '0;
      repeat (3) @(negedge clk);
      // R1: reset state
      n_vec++;
      if ({busy, field_en, done} !== 3'b000) begin
         n_bad++;
         $display("FAIL R1 reset outputs actual %b expected 000", {busy, field_en, done});
      end
      rst = 1'b0;
      check_idle("R1", 20);

      // Directed frames
      run_frame(64'h0, 16'h0, 0, 64'hFFFF_FFFF_FFFF_FFFF);
      run_frame(64'hFFFF_FFFF_FFFF_FFFF, 16'hFFFF, TEND, 64'h0);      // R9 start in done cycle
      run_frame(64'h0123_4567_89AB_CDEF, 16'hA55A, TEND - 1, 64'h1);
      check_idle("R8", 10);

      // Random frames with a stray start somewhere in the session
      for (int k = 0; k < 4; k++) begin
         logic [63:0] rid;
         rid = {$urandom, $urandom};
         run_frame(rid, 16'($urandom), int'($urandom_range(0, TEND)), {$urandom, $urandom});
      end

      // R11: reset in mid-session
      @(negedge clk);
      tag_id = 64'hDEAD_BEEF_0000_1111; tag_crc = 16'h1234; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (700) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      n_vec++;
      if ({busy, field_en, done} !== 3'b000) begin
         n_bad++;
         $display("FAIL R11 after reset actual %b expected 000", {busy, field_en, done});
      end
      check_idle("R11", 30);

      // Block still works after the abort
      run_frame(64'h8000_0000_0000_0001, 16'h0080, TEND / 2, 64'h5);

      summary();
      $finish;
   end

endmodule